// File: doc/BRIEF.md
# Multicore inter-processor interrupt controller

This block lets any core of a small multiprocessor raise an interrupt on another core and hand it a 16-bit message. Each core owns a private pair of 32-bit registers, a command register and a mailbox register, on a simple register bus made of an address, a write enable, write data and combinational read data. One interrupt line per core leaves the block. The line of a core is high exactly while the pending flag of its mailbox is set.

A core sends a message by writing its own command register with the raise bit set, a destination core number and a payload. The block fills the destination mailbox with the pending flag, the sender's index and the payload, and raises the destination's line. The receiver reads its mailbox and then writes the acknowledge bit into its own command register. That clears its pending flag and drops its line. One write may both send to another core and acknowledge the writer's own interrupt.

Top module: `ipi_ctrl`

## Requirements
- R1: Address bit 2 selects the register (0 = command, 1 = mailbox) and address bits 3 and up select the core, giving an 8-byte stride per core. An address whose core field is at or above NUM_CORES reads as zero, and a write to it changes nothing.
- R2: Every write to a command register stores the whole 32-bit word, and a read of that register returns it.
- R3: A command write with bit 30 (raise) set and a destination in bits 29:16 below NUM_CORES loads the destination mailbox with bit 31 = 0, bit 30 (pending) = 1, bits 29:16 = writer's core index and bits 15:0 = written bits 15:0. The destination's interrupt line is high from the clock edge that takes the write.
- R4: A command write with bit 31 (acknowledge) set clears only bit 30 of the writer's own mailbox and drops the writer's line on that edge. Source and payload are kept. An acknowledge with nothing pending changes nothing.
- R5: When one write sets both bit 30 and bit 31 and names the writer itself as destination, the raise wins: the mailbox is reloaded with pending set and the line stays high.
- R6: Writes to a mailbox register have no effect on any register or line.
- R7: A raise whose destination is at or above NUM_CORES changes no mailbox and raises no line. The written word is still stored, and any acknowledge in the same word still applies.
- R8: Reset, active low and asynchronous, clears all command and mailbox registers and drops every interrupt line.
- R9: A raise to a core whose flag is already pending overwrites its source and payload with those of the newest request.
- R10: Each interrupt line equals the pending bit of its own mailbox at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for one cycle |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | NUM_CORES | One interrupt line per core |

## Verification
Raise and acknowledge can fall on the same core in the same cycle only when a core writes its own command register with both bits set and names itself as destination. The bench provokes this with directed writes, once with the flag already pending and once with it clear, and the random stream sets both bits with a high weight and often picks the writer as destination. Both cases are judged against a reference model that applies the raise after the acknowledge. The bench compares the mailbox readback and the line after the edge.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ACK_BIT  = 31;
  localparam int unsigned RAISE_BIT = 30;
  localparam int unsigned PEND_BIT = 30;
  localparam int unsigned NODE_LSB = 16;
  localparam int unsigned NODE_W   = 14;
  localparam int unsigned MSG_W    = 16;

  typedef logic [NODE_W-1:0] node_t;
  typedef logic [MSG_W-1:0]  msg_t;

  typedef struct packed {
    logic  rsvd;
    logic  pending;
    node_t src;
    msg_t  msg;
  } mailbox_t;

  function automatic mailbox_t make_mailbox(node_t src, msg_t msg);
    mailbox_t m;
    m.rsvd    = 1'b0;
    m.pending = 1'b1;
    m.src     = src;
    m.msg     = msg;
    return m;
  endfunction
endpackage

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned FIELD_W  = ADDR_W - 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CORE_W-1:0] core_o,
  output logic              sel_mbox_o,
  output logic              in_range_o
);
  logic [FIELD_W-1:0] field;

  assign field      = addr_i[ADDR_W-1:3];
  assign sel_mbox_o = addr_i[2];
  assign in_range_o = (field < FIELD_W'(NUM_CORES));
  assign core_o     = field[CORE_W-1:0];
endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
  import ipi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              raise_i,
  input  mailbox_t          raise_word_i,
  output logic [WORD_W-1:0] cmd_o,
  output mailbox_t          mbox_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] cmd_q;
  mailbox_t          mbox_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else if (cmd_we_i) cmd_q <= wdata_i;
  end

  // raise is applied after acknowledge, so it wins on self-targeting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbox_q <= '0;
    end else if (raise_i) begin
      mbox_q <= raise_word_i;
    end else if (cmd_we_i && wdata_i[ACK_BIT]) begin
      mbox_q.pending <= 1'b0;
    end
  end

  assign cmd_o  = cmd_q;
  assign mbox_o = mbox_q;
  assign irq_o  = mbox_q.pending;
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic [NUM_CORES-1:0] irq_o
);
  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [CORE_W-1:0] core;
  logic              sel_mbox, in_range;
  node_t             dest;
  logic              dest_ok;
  mailbox_t          raise_word;
  logic              cmd_wr;

  logic [WORD_W-1:0] cmd_q  [NUM_CORES];
  mailbox_t          mbox_q [NUM_CORES];

  ipi_addr_dec #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
    .addr_i     (addr_i),
    .core_o     (core),
    .sel_mbox_o (sel_mbox),
    .in_range_o (in_range)
  );

  assign cmd_wr     = we_i && in_range && !sel_mbox;
  assign dest       = wdata_i[NODE_LSB +: NODE_W];
  assign dest_ok    = (dest < NODE_W'(NUM_CORES));
  assign raise_word = make_mailbox(NODE_W'(core), wdata_i[MSG_W-1:0]);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
    logic own_wr, hit;
    assign own_wr = cmd_wr && (core == CORE_W'(c));
    assign hit    = cmd_wr && wdata_i[RAISE_BIT] && dest_ok && (dest == NODE_W'(c));

    ipi_slot u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cmd_we_i     (own_wr),
      .wdata_i      (wdata_i),
      .raise_i      (hit),
      .raise_word_i (raise_word),
      .cmd_o        (cmd_q[c]),
      .mbox_o       (mbox_q[c]),
      .irq_o        (irq_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (in_range && core == CORE_W'(c))
        rdata_o = sel_mbox ? WORD_W'(mbox_q[c]) : cmd_q[c];
    end
  end
endmodule

// File: rtl/ipi_ctrl_chk.sv
module ipi_ctrl_chk
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [WORD_W-1:0]    wdata_i,
  input logic [NUM_CORES-1:0] irq_o
);
  logic [ADDR_W-4:0] fld;
  logic              cmd_w;
  node_t             dst;

  assign fld   = addr_i[ADDR_W-1:3];
  assign cmd_w = we_i && !addr_i[2] && (fld < (ADDR_W-3)'(NUM_CORES));
  assign dst   = wdata_i[29:16];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
    AST_RAISE_SETS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_w && wdata_i[30] && dst == NODE_W'(c) |=> irq_o[c]); // R3
    AST_ACK_DROPS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_w && fld == (ADDR_W-3)'(c) && wdata_i[31] && !(wdata_i[30] && dst == NODE_W'(c))
      |=> !irq_o[c]); // R4
    AST_SELF_RAISE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_w && fld == (ADDR_W-3)'(c) && wdata_i[31] && wdata_i[30] && dst == NODE_W'(c)
      |=> irq_o[c]); // R5
  end

  AST_MBOX_WRITE_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i[2] |=> $stable(irq_o)); // R6
  AST_BAD_DEST_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wdata_i[30] && !wdata_i[31] && dst >= NODE_W'(NUM_CORES) |=> $stable(irq_o)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(irq_o)); // R10
endmodule

bind ipi_ctrl ipi_ctrl_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_o  (irq_o)
);

// File: tb/tb_ipi_ctrl.sv
`timescale 1ns/1ps
module tb_ipi_ctrl;
  localparam int N  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_cmd [N];
  logic [31:0] m_box [N];

  always #2.5 clk = ~clk;

  ipi_ctrl #(.NUM_CORES(N), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  initial begin
    #900000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_irq();
    logic [N-1:0] v;
    for (int c = 0; c < N; c++) v[c] = m_box[c][30];
    return v;
  endfunction

  // model of one write, applied at the clock edge
  task automatic model_wr(input logic [AW-1:0] a, input logic [31:0] d);
    int core = int'(a[AW-1:3]);
    int dst  = int'(d[29:16]);
    if (core >= N || a[2]) return;
    m_cmd[core] = d;
    if (d[31]) m_box[core][30] = 1'b0;
    if (d[30] && dst < N) m_box[dst] = {2'b01, 14'(core), d[15:0]};
  endtask

  // called at a negedge: drive, take edge, return at next negedge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    model_wr(a, d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    addr = a; #1;
    cmp(req, rdata, exp);
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < N; c++) begin
      rd_chk(req, AW'(c*8), m_cmd[c]);
      rd_chk(req, AW'(c*8+4), m_box[c]);
    end
    cmp({req, "/R10 irq"}, 32'(irq), 32'(exp_irq()));
  endtask

  function automatic logic [31:0] cmd(input bit ack, input bit raise, input int dst, input logic [15:0] msg);
    return {ack, raise, 14'(dst), msg};
  endfunction

  initial begin
    void'($urandom(1234));
    for (int c = 0; c < N; c++) begin m_cmd[c] = '0; m_box[c] = '0; end
    #1;
    cmp("R8 irq in reset", 32'(irq), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R8 after reset");

    // R2 store and read back, R1 stride
    wr(8'h10, 32'h1234_5678);
    check_all("R2/R1 store");
    rd_chk("R1 core2 cmd", 8'h10, 32'h1234_5678);
    // R1 out-of-range core
    wr(8'h20, cmd(0, 1, 1, 16'hdead));
    check_all("R1 oor write ignored");
    rd_chk("R1 oor read zero", 8'h24, 32'h0);

    // R3 raise core0 -> core3
    wr(8'h00, cmd(0, 1, 3, 16'hbeef));
    rd_chk("R3 mailbox", 8'h1c, 32'h4000_beef);
    cmp("R3 irq", 32'(irq), 32'h8);
    // R9 overwrite from core1
    wr(8'h08, cmd(0, 1, 3, 16'h0042));
    rd_chk("R9 overwrite", 8'h1c, 32'h4001_0042);
    // R6 mailbox write ignored
    wr(8'h1c, 32'h0000_0000);
    check_all("R6 mailbox write");
    // R4 ack keeps src and payload
    wr(8'h18, cmd(1, 0, 0, 16'h0));
    rd_chk("R4 ack clears pend", 8'h1c, 32'h0001_0042);
    cmp("R4 irq", 32'(irq), 32'h0);
    // R4 ack with nothing pending
    wr(8'h18, cmd(1, 0, 0, 16'h0));
    check_all("R4 idle ack");
    // R5 self raise + ack, pending clear then pending set
    wr(8'h08, cmd(1, 1, 1, 16'h5a5a));
    rd_chk("R5 self clear", 8'h0c, 32'h4001_5a5a);
    wr(8'h08, cmd(1, 1, 1, 16'ha5a5));
    rd_chk("R5 self pending", 8'h0c, 32'h4001_a5a5);
    cmp("R5 irq", 32'(irq[1]), 32'h1);
    // R7 bad destination, with ack
    wr(8'h08, cmd(1, 1, N, 16'h7777));
    check_all("R7 bad dest");
    wr(8'h00, cmd(0, 1, 14'h3fff, 16'h1));
    check_all("R7 far dest");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [31:0]   d;
      int core = $urandom_range(0, N);
      a = AW'(core*8 + (($urandom_range(0, 5) == 0) ? 4 : 0));
      d = cmd($urandom_range(0, 2) == 0, $urandom_range(0, 3) != 0,
              ($urandom_range(0, 2) == 0) ? core : $urandom_range(0, N),
              16'($urandom));
      wr(a, d);
      check_all("R3/R4/R5 random");
    end

    // R8 reset mid-run
    wr(8'h00, cmd(0, 1, 2, 16'h9));
    rst_n = 1'b0;
    for (int c = 0; c < N; c++) begin m_cmd[c] = '0; m_box[c] = '0; end
    #1;
    check_all("R8 async reset");
    @(negedge clk); rst_n = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule